// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block times the four control strobes of a multiplexed external bus: the address-latch pulse (active high), the code-read strobe, and the data read and data write strobes (all three active low). It runs from the oscillator clock. Each machine cycle is twelve clock periods long, split into six states of two phases each. The block reports the current state and phase so that the rest of the core can align its own work with the bus.

The surrounding core describes each machine cycle with a few plain flags. The flags say whether the code fetch is external or internal, whether the external-execution strap is tied on, whether the cycle is a data-memory access and in which direction, and whether it is a table read. One more input is a control bit that silences the address-latch pulse during internal fetches. The block samples all of these flags at the clock edge that opens a machine cycle and holds them for the whole cycle.

In a data-memory cycle the second address-latch pulse and both code-read pulses are dropped. The read or write strobe takes their place for six clocks. The block has no data path, so every pin is a plain control or status signal and none of them uses a handshake.

Top module: `bus_strobe_seq`

## Requirements
- R1: The first clock edge after reset enters state 1, phase 0. The block then advances one phase per clock: phase goes 0,1, and state goes 1..6 and wraps to 1. A machine cycle is therefore 12 clocks. Slot index j = 2*(state-1)+phase.
- R2: While reset is held, `ale_o`=0, `psen_n_o`=1, `rd_n_o`=1, `wr_n_o`=1, `state_o`=6 and `phase_o`=1.
- R3: In a cycle that is neither a data cycle nor silenced, `ale_o` is high in slots 0,1 and 6,7 and low in the other slots.
- R4: In a cycle that is not a data cycle, `psen_n_o` is low in slots 3,4,5 and 9,10,11 when `ext_fetch_i` or `ext_strap_i` is 1. In all other cycles `psen_n_o` stays high.
- R5: In a data cycle (`data_cyc_i`=1), `ale_o` is high only in slots 0,1 and `psen_n_o` stays high. The data strobe is low in slots 5..10: `rd_n_o` when `data_wr_i`=0, `wr_n_o` when `data_wr_i`=1.
- R6: A cycle is silenced when `ale_off_i`=1 and `ext_strap_i`, `ext_fetch_i`, `table_rd_i` and `data_cyc_i` are all 0. In a silenced cycle `ale_o` rests high for all 12 slots.
- R7: `ale_off_i` has no effect on the strobes when `ext_strap_i`, `ext_fetch_i`, `table_rd_i` or `data_cyc_i` is 1.
- R8: The cycle flags are sampled only at the edge that enters slot 0. Changes to them later in the cycle do not alter that cycle's strobes.
- R9: `rd_n_o` and `wr_n_o` are never low together, and `psen_n_o` is never low while either of them is low.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_fetch_i | input | 1 | Code fetch of this cycle comes from external memory |
| ext_strap_i | input | 1 | External-execution strap; forces every fetch external |
| data_cyc_i | input | 1 | Cycle is an external data-memory access |
| data_wr_i | input | 1 | Data access direction: 1 write, 0 read |
| table_rd_i | input | 1 | Cycle is a table read |
| ale_off_i | input | 1 | Silence address-latch pulses on internal fetches |
| ale_o | output | 1 | Address-latch pulse, active high |
| psen_n_o | output | 1 | Code-read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| state_o | output | 3 | Current state, 1..6 |
| phase_o | output | 1 | Current phase, 0 or 1 |

## Verification
The bench runs back-to-back data cycles and silenced cycles next to normal ones. A decoder that let the silencing bit win over the strap, a table read or a data access would hold the latch line high where pulses are expected. In every cycle the bench rewrites the flags in the middle of the cycle. A design that followed its inputs live instead of sampling them at the cycle boundary would show strobes that shift part-way through the cycle. Data cycles of both directions also check that the strobe lands in slots 5..10 and on the correct pin. This catches a pulse that is one slot off, a read and write that are swapped, or a leftover code-read pulse.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  // Attributes of one machine cycle, frozen at its first edge
  typedef struct packed {
    logic data;   // external data-memory access
    logic wr;     // direction of the data access
    logic ext;    // code-read strobe pulses this cycle
    logic quiet;  // address-latch line held at rest
  } cyc_attr_t;

  localparam cyc_attr_t ATTR_IDLE = '{data: 1'b0, wr: 1'b0, ext: 1'b0, quiet: 1'b0};

  // True when slot s falls inside [lo, lo+w)
  function automatic logic in_win(input int s, input int lo, input int w);
    return (s >= lo) && (s < lo + w);
  endfunction

endpackage

// File: rtl/bus_slot_timer.sv
module bus_slot_timer #(
  parameter int PHASES = 2,
  parameter int STATES = 6,
  localparam int SLOTS = PHASES * STATES,
  localparam int SW    = $clog2(SLOTS),
  localparam int PW    = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int STW   = $clog2(STATES + 1)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [SW-1:0]  slot_nx,
  output logic           start_nx,
  output logic [STW-1:0] state_o,
  output logic [PW-1:0]  phase_o
);

  localparam logic [SW-1:0]  LAST_SLOT  = SW'(SLOTS - 1);
  localparam logic [PW-1:0]  LAST_PHASE = PW'(PHASES - 1);
  localparam logic [STW-1:0] LAST_STATE = STW'(STATES);
  localparam logic [STW-1:0] FIRST_ST   = STW'(1);

  logic [SW-1:0]  slot_q;
  logic [PW-1:0]  ph_q;
  logic [STW-1:0] st_q;

  always_comb begin
    slot_nx  = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    start_nx = (slot_nx == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= LAST_SLOT;
      ph_q   <= LAST_PHASE;
      st_q   <= LAST_STATE;
    end else begin
      slot_q <= slot_nx;
      if (ph_q == LAST_PHASE) begin
        ph_q <= '0;
        st_q <= (st_q == LAST_STATE) ? FIRST_ST : st_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign state_o = st_q;
  assign phase_o = ph_q;

endmodule

// File: rtl/bus_cycle_latch.sv
module bus_cycle_latch
  import bus_strobe_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_nx,
  input  logic      ext_fetch_i,
  input  logic      ext_strap_i,
  input  logic      data_cyc_i,
  input  logic      data_wr_i,
  input  logic      table_rd_i,
  input  logic      ale_off_i,
  output cyc_attr_t attr_nx
);

  cyc_attr_t fresh;
  cyc_attr_t attr_q;

  // The silencing bit only applies to plain internal fetches
  always_comb begin
    fresh.data  = data_cyc_i;
    fresh.wr    = data_cyc_i & data_wr_i;
    fresh.ext   = ext_fetch_i | ext_strap_i;
    fresh.quiet = ale_off_i & ~ext_strap_i & ~ext_fetch_i
                & ~table_rd_i & ~data_cyc_i;
    attr_nx     = start_nx ? fresh : attr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) attr_q <= ATTR_IDLE;
    else     attr_q <= attr_nx;
  end

endmodule

// File: rtl/bus_strobe_decode.sv
module bus_strobe_decode
  import bus_strobe_pkg::*;
#(
  parameter int SLOTS     = 12,
  parameter int ALE_W     = 2,
  parameter int PSEN_LEAD = 3,
  parameter int PSEN_W    = 3,
  parameter int XS_GAP    = 3,
  parameter int XS_W      = 6,
  localparam int SW       = $clog2(SLOTS),
  localparam int HALF     = SLOTS / 2,
  localparam int XS_START = ALE_W + XS_GAP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] slot_nx,
  input  cyc_attr_t     attr_nx,
  output logic          ale_o,
  output logic          psen_n_o,
  output logic          rd_n_o,
  output logic          wr_n_o
);

  logic [1:0] ale_win;
  logic [1:0] psen_win;
  logic       xs_win;
  logic       ale_d, psen_n_d, rd_n_d, wr_n_d;

  // One latch window and one code-read window per half cycle
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_comb begin
      ale_win[h]  = in_win(int'(slot_nx), h * HALF, ALE_W);
      psen_win[h] = in_win(int'(slot_nx), h * HALF + PSEN_LEAD, PSEN_W);
    end
  end

  always_comb begin
    xs_win = in_win(int'(slot_nx), XS_START, XS_W);
    if (attr_nx.quiet)     ale_d = 1'b1;
    else if (attr_nx.data) ale_d = ale_win[0];
    else                   ale_d = |ale_win;
    psen_n_d = ~(attr_nx.ext & ~attr_nx.data & (|psen_win));
    rd_n_d   = ~(attr_nx.data & ~attr_nx.wr & xs_win);
    wr_n_d   = ~(attr_nx.data &  attr_nx.wr & xs_win);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_o    <= 1'b0;
      psen_n_o <= 1'b1;
      rd_n_o   <= 1'b1;
      wr_n_o   <= 1'b1;
    end else begin
      ale_o    <= ale_d;
      psen_n_o <= psen_n_d;
      rd_n_o   <= rd_n_d;
      wr_n_o   <= wr_n_d;
    end
  end

endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
  import bus_strobe_pkg::*;
#(
  parameter int PHASES    = 2,
  parameter int STATES    = 6,
  parameter int ALE_W     = 2,
  parameter int PSEN_LEAD = 3,
  parameter int PSEN_W    = 3,
  parameter int XS_GAP    = 3,
  parameter int XS_W      = 6,
  localparam int SLOTS    = PHASES * STATES,
  localparam int SW       = $clog2(SLOTS),
  localparam int PW       = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int STW      = $clog2(STATES + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ext_fetch_i,
  input  logic           ext_strap_i,
  input  logic           data_cyc_i,
  input  logic           data_wr_i,
  input  logic           table_rd_i,
  input  logic           ale_off_i,
  output logic           ale_o,
  output logic           psen_n_o,
  output logic           rd_n_o,
  output logic           wr_n_o,
  output logic [STW-1:0] state_o,
  output logic [PW-1:0]  phase_o
);

  logic [SW-1:0] slot_nx;
  logic          start_nx;
  cyc_attr_t     attr_nx;

  bus_slot_timer #(.PHASES(PHASES), .STATES(STATES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .slot_nx  (slot_nx),
    .start_nx (start_nx),
    .state_o  (state_o),
    .phase_o  (phase_o)
  );

  bus_cycle_latch u_latch (
    .clk         (clk),
    .rst         (rst),
    .start_nx    (start_nx),
    .ext_fetch_i (ext_fetch_i),
    .ext_strap_i (ext_strap_i),
    .data_cyc_i  (data_cyc_i),
    .data_wr_i   (data_wr_i),
    .table_rd_i  (table_rd_i),
    .ale_off_i   (ale_off_i),
    .attr_nx     (attr_nx)
  );

  bus_strobe_decode #(
    .SLOTS(SLOTS), .ALE_W(ALE_W), .PSEN_LEAD(PSEN_LEAD),
    .PSEN_W(PSEN_W), .XS_GAP(XS_GAP), .XS_W(XS_W)
  ) u_decode (
    .clk      (clk),
    .rst      (rst),
    .slot_nx  (slot_nx),
    .attr_nx  (attr_nx),
    .ale_o    (ale_o),
    .psen_n_o (psen_n_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o)
  );

endmodule

// File: rtl/bus_strobe_seq_chk.sv
module bus_strobe_seq_chk #(
  parameter int STATES = 6,
  localparam int STW   = $clog2(STATES + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           ale,
  input logic           psen_n,
  input logic           rd_n,
  input logic           wr_n,
  input logic [STW-1:0] state,
  input logic           phase
);

  // R9
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R9
  psen_vs_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> psen_n);

  // R1
  phase_alt_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase != $past(phase)));

  // R1
  state_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state >= STW'(1)) && (state <= STW'(STATES)));

  // R5
  data_start_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n) || $fell(wr_n)) |-> (state == STW'(3) && phase == 1'b1));

  // R4
  psen_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n) |-> (phase == 1'b1 && (state == STW'(2) || state == STW'(5))));

  // R3
  ale_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |-> (phase == 1'b0 && (state == STW'(1) || state == STW'(4))));

endmodule

bind bus_strobe_seq bus_strobe_seq_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .ale    (ale_o),
  .psen_n (psen_n_o),
  .rd_n   (rd_n_o),
  .wr_n   (wr_n_o),
  .state  (state_o),
  .phase  (phase_o)
);

// File: tb/tb_bus_strobe_seq.sv
module tb_bus_strobe_seq;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_fetch, ext_strap, data_cyc, data_wr, table_rd, ale_off;
  logic ale, psen_n, rd_n, wr_n, phase;
  logic [2:0] state;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_strobe_seq dut (
    .clk(clk), .rst(rst),
    .ext_fetch_i(ext_fetch), .ext_strap_i(ext_strap), .data_cyc_i(data_cyc),
    .data_wr_i(data_wr), .table_rd_i(table_rd), .ale_off_i(ale_off),
    .ale_o(ale), .psen_n_o(psen_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
    .state_o(state), .phase_o(phase)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // Expected {ale, psen_n, rd_n, wr_n} for slot j of a cycle with the given flags
  function automatic logic [3:0] exp_strobes(input int j, input logic [5:0] f);
    logic fe, st, dc, dw, tr, ao, quiet, ext, xs, a, p;
    {fe, st, dc, dw, tr, ao} = f;
    quiet = ao && !st && !fe && !tr && !dc;
    ext   = fe || st;
    xs    = dc && (j >= 5) && (j <= 10);
    if (quiet)   a = 1'b1;
    else if (dc) a = (j < 2);
    else         a = ((j % 6) < 2);
    p = !(ext && !dc && ((j % 6) >= 3));
    return {a, p, !(xs && !dw), !(xs && dw)};
  endfunction

  function automatic string tag_of(input logic [5:0] f);
    logic fe, st, dc, dw, tr, ao;
    {fe, st, dc, dw, tr, ao} = f;
    if (dc) return "R5";
    if (ao && !st && !fe && !tr) return "R6";
    if (ao) return "R7";
    if (fe || st) return "R4";
    return "R3";
  endfunction

  task automatic drive(input logic [5:0] f);
    {ext_fetch, ext_strap, data_cyc, data_wr, table_rd, ale_off} = f;
  endtask

  // Runs one machine cycle; called at a falling edge before the cycle's first rising edge
  task automatic run_cycle(input logic [5:0] f);
    drive(f);
    for (int j = 0; j < 12; j++) begin
      @(posedge clk);
      @(negedge clk);
      check((j > 4) ? "R8" : tag_of(f), {4'h0, ale, psen_n, rd_n, wr_n},
            {4'h0, exp_strobes(j, f)});
      check("R1", {4'h0, state, phase}, {4'h0, 3'(j / 2 + 1), 1'(j % 2)});
      check("R9", {7'h0, !((!rd_n && !wr_n) || (!psen_n && (!rd_n || !wr_n)))}, 8'h1);
      if (j == 4) drive(6'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'd7731));
    drive(6'b000000);
    repeat (3) @(negedge clk);
    // R2: reset values
    check("R2", {2'b0, ale, psen_n, rd_n, wr_n, state[1:0]}, 8'b00_0111_10);
    check("R2", {4'h0, state, phase}, {4'h0, 3'd6, 1'b1});
    rst = 1'b0;
    // flag order: {ext_fetch, ext_strap, data_cyc, data_wr, table_rd, ale_off}
    run_cycle(6'b000000);  // R3 internal fetch
    run_cycle(6'b100000);  // R4 external fetch
    run_cycle(6'b010000);  // R4 strap
    run_cycle(6'b001000);  // R5 read
    run_cycle(6'b001100);  // R5 write
    run_cycle(6'b001100);  // R5 back-to-back write
    run_cycle(6'b000001);  // R6 silenced
    run_cycle(6'b000001);  // R6 silenced twice
    run_cycle(6'b000000);  // R3 after silenced
    run_cycle(6'b010001);  // R7 strap overrides
    run_cycle(6'b000011);  // R7 table read
    run_cycle(6'b100001);  // R7 external fetch
    run_cycle(6'b001001);  // R7 data read with silencing bit
    run_cycle(6'b001101);  // R7 data write with silencing bit
    for (int k = 0; k < 60; k++) run_cycle(6'($urandom));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule